// File: doc/BRIEF.md
# Down-Counting Event Timer

This block is a small memory-mapped timer that gives an operating-system scheduler its tick or its next deadline. Software programs a reload value and a current count, chooses between single-expiry and repeating operation, sets a clock divider, and enables counting. The count falls by one on every divided tick. When it reaches zero the block sets a sticky event flag, which drives a level interrupt while the interrupt enable is set.

Four word registers are selected by the byte address: reload value at 0x0, live count at 0x4, control at 0x8 and event status at 0xC. Reads are combinational from the registered state and writes take effect at the clock edge. Because the live count can be written on its own, the first expiry can come after a different interval from the later ones in repeating mode.

Top module: `dcount_evt_timer`

## Requirements
- R1: After reset every register reads zero and `irq_out` is low.
- R2: Control register layout: bit 0 runs the counter, bit 1 selects repeating (reload) mode, bit 2 enables the interrupt, and bits [15:8] hold the divider value. Every other control bit reads back as zero.
- R3: A write to the reload register (0x0) stores the value and also copies it into the live count (0x4). Both read back.
- R4: While running, the live count falls by one once every (divider + 1) clocks. The first decrement comes (divider + 1) clocks after the control write that starts it.
- R5: In single-expiry mode, a decrement from 1 to 0 sets the event flag (status bit 0). The count then stays at zero, and no further event occurs.
- R6: In repeating mode, the tick that would take the count from 1 to 0 sets the event flag and loads the reload value instead. The first interval is set by a separate write to the live count, and every later interval equals the reload value.
- R7: Writing 1 to status bit 0 clears the event flag. Writing 0 to it leaves the flag unchanged.
- R8: `irq_out` is high exactly when the event flag is set and the interrupt enable bit is set.
- R9: Writing zero to the control register stops the counter, and the live count then holds its value.
- R10: If an expiry and a software clear of the flag fall in the same cycle, the flag ends up set.
- R11: An access whose address has bits [1:0] non-zero is ignored. Such a read returns zero, and such a write changes no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W | Byte address of the register access |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for the addressed register |
| irq_out | output | 1 | Level interrupt request |

## Verification
The assertions assume that the address, write strobe and write data are known and steady across each rising edge. They also assume that a write is a single-cycle strobe, so that a reload or count write in the same cycle as a tick can be recognised from the bus alone. The stimulus changes bus inputs only just after an edge and holds each write for exactly one cycle. It also times the one flag clear that must collide with an expiry so that the two land on the same edge.

// File: rtl/dcevt_pkg.sv
package dcevt_pkg;

   // Register selector taken from byte address bits [3:2]
   typedef enum logic [1:0] {
      SEL_RELOAD = 2'd0,
      SEL_LIVE   = 2'd1,
      SEL_CTRL   = 2'd2,
      SEL_STAT   = 2'd3
   } reg_sel_e;

   // Control image bit positions
   localparam int unsigned BIT_RUN      = 0;
   localparam int unsigned BIT_REPEAT   = 1;
   localparam int unsigned BIT_IRQ_EN   = 2;
   localparam int unsigned DIV_LSB      = 8;

   // Status bit position
   localparam int unsigned BIT_EVT      = 0;

endpackage

// File: rtl/dcevt_prescale.sv
module dcevt_prescale #(
   parameter int unsigned DIV_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             restart,
   input  logic [DIV_W-1:0] div_val,
   output logic             tick
);

   logic [DIV_W-1:0] phase_q;

   assign tick = run && (phase_q == div_val);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase_q <= '0;
      end else if (!run || restart || tick) begin
         phase_q <= '0;
      end else begin
         phase_q <= phase_q + DIV_W'(1);
      end
   end

endmodule

// File: rtl/dcevt_counter.sv
module dcevt_counter #(
   parameter int unsigned CNT_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_reload,
   input  logic             wr_live,
   input  logic [CNT_W-1:0] wr_val,
   input  logic             tick,
   input  logic             repeat_en,
   output logic [CNT_W-1:0] reload_q,
   output logic [CNT_W-1:0] live_q,
   output logic             expire
);

   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   logic sw_touch;
   logic at_one;

   assign sw_touch = wr_reload || wr_live;
   assign at_one   = (live_q == ONE);
   // software writes win over the tick in the same cycle
   assign expire   = tick && at_one && !sw_touch;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         reload_q <= '0;
         live_q   <= '0;
      end else begin
         if (wr_reload) begin
            reload_q <= wr_val;
         end
         if (sw_touch) begin
            live_q <= wr_val;
         end else if (tick) begin
            if (at_one) begin
               live_q <= repeat_en ? reload_q : '0;
            end else if (live_q != '0) begin
               live_q <= live_q - ONE;
            end else if (repeat_en) begin
               live_q <= reload_q;
            end
         end
      end
   end

endmodule

// File: rtl/dcevt_regs.sv
module dcevt_regs
   import dcevt_pkg::*;
#(
   parameter int unsigned DATA_W = 32,
   parameter int unsigned ADDR_W = 4,
   parameter int unsigned CNT_W  = 32,
   parameter int unsigned DIV_W  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_we,
   input  logic [DATA_W-1:0] bus_wdata,
   input  logic              expire,
   input  logic [CNT_W-1:0]  reload_q,
   input  logic [CNT_W-1:0]  live_q,
   output logic              run_en,
   output logic              repeat_en,
   output logic              irq_en,
   output logic [DIV_W-1:0]  div_val,
   output logic              evt_q,
   output logic              wr_reload,
   output logic              wr_live,
   output logic              wr_ctrl,
   output logic [DATA_W-1:0] bus_rdata
);

   localparam logic [DATA_W-1:0] CTRL_MASK =
      (DATA_W'(1) << BIT_RUN) | (DATA_W'(1) << BIT_REPEAT) |
      (DATA_W'(1) << BIT_IRQ_EN) |
      (((DATA_W'(1) << DIV_W) - DATA_W'(1)) << DIV_LSB);

   logic              upper_ok;
   logic              hit;
   logic              wr_stat;
   reg_sel_e          sel;
   logic [DATA_W-1:0] ctrl_img_q;

   generate
      if (ADDR_W > 4) begin : g_wide_addr
         assign upper_ok = (bus_addr[ADDR_W-1:4] == '0);
      end else begin : g_narrow_addr
         assign upper_ok = 1'b1;
      end
   endgenerate

   assign sel       = reg_sel_e'(bus_addr[3:2]);
   assign hit       = upper_ok && (bus_addr[1:0] == 2'b00);
   assign wr_reload = bus_we && hit && (sel == SEL_RELOAD);
   assign wr_live   = bus_we && hit && (sel == SEL_LIVE);
   assign wr_ctrl   = bus_we && hit && (sel == SEL_CTRL);
   assign wr_stat   = bus_we && hit && (sel == SEL_STAT);

   assign run_en    = ctrl_img_q[BIT_RUN];
   assign repeat_en = ctrl_img_q[BIT_REPEAT];
   assign irq_en    = ctrl_img_q[BIT_IRQ_EN];
   assign div_val   = ctrl_img_q[DIV_LSB +: DIV_W];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctrl_img_q <= '0;
         evt_q      <= 1'b0;
      end else begin
         if (wr_ctrl) begin
            ctrl_img_q <= bus_wdata & CTRL_MASK;
         end
         // hardware set outranks a software clear
         if (expire) begin
            evt_q <= 1'b1;
         end else if (wr_stat && bus_wdata[BIT_EVT]) begin
            evt_q <= 1'b0;
         end
      end
   end

   always_comb begin
      bus_rdata = '0;
      if (hit) begin
         unique case (sel)
            SEL_RELOAD: bus_rdata[CNT_W-1:0] = reload_q;
            SEL_LIVE:   bus_rdata[CNT_W-1:0] = live_q;
            SEL_CTRL:   bus_rdata            = ctrl_img_q;
            SEL_STAT:   bus_rdata[BIT_EVT]   = evt_q;
            default:    bus_rdata            = '0;
         endcase
      end
   end

endmodule

// File: rtl/dcount_evt_timer.sv
module dcount_evt_timer
   import dcevt_pkg::*;
#(
   parameter int unsigned DATA_W = 32,
   parameter int unsigned ADDR_W = 4,
   parameter int unsigned CNT_W  = 32,
   parameter int unsigned DIV_W  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_we,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              irq_out
);

   generate
      if (ADDR_W < 4) begin : g_bad_addr
         $error("dcount_evt_timer: ADDR_W must cover four word registers");
      end
      if (CNT_W > DATA_W || CNT_W < 2) begin : g_bad_cnt
         $error("dcount_evt_timer: CNT_W must lie in 2..DATA_W");
      end
      if (DIV_W < 1 || DIV_LSB + DIV_W > DATA_W) begin : g_bad_div
         $error("dcount_evt_timer: divider field does not fit the control word");
      end
   endgenerate

   logic             run_en;
   logic             repeat_en;
   logic             irq_en;
   logic [DIV_W-1:0] div_val;
   logic             evt_q;
   logic             wr_reload;
   logic             wr_live;
   logic             wr_ctrl;
   logic             tick;
   logic             expire;
   logic [CNT_W-1:0] reload_q;
   logic [CNT_W-1:0] live_q;

   dcevt_regs #(
      .DATA_W (DATA_W),
      .ADDR_W (ADDR_W),
      .CNT_W  (CNT_W),
      .DIV_W  (DIV_W)
   ) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_addr  (bus_addr),
      .bus_we    (bus_we),
      .bus_wdata (bus_wdata),
      .expire    (expire),
      .reload_q  (reload_q),
      .live_q    (live_q),
      .run_en    (run_en),
      .repeat_en (repeat_en),
      .irq_en    (irq_en),
      .div_val   (div_val),
      .evt_q     (evt_q),
      .wr_reload (wr_reload),
      .wr_live   (wr_live),
      .wr_ctrl   (wr_ctrl),
      .bus_rdata (bus_rdata)
   );

   dcevt_prescale #(
      .DIV_W (DIV_W)
   ) u_prescale (
      .clk     (clk),
      .rst_n   (rst_n),
      .run     (run_en),
      .restart (wr_ctrl || wr_reload || wr_live),
      .div_val (div_val),
      .tick    (tick)
   );

   dcevt_counter #(
      .CNT_W (CNT_W)
   ) u_counter (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_reload (wr_reload),
      .wr_live   (wr_live),
      .wr_val    (bus_wdata[CNT_W-1:0]),
      .tick      (tick),
      .repeat_en (repeat_en),
      .reload_q  (reload_q),
      .live_q    (live_q),
      .expire    (expire)
   );

   assign irq_out = evt_q && irq_en;

endmodule

// File: rtl/dcevt_checker.sv
module dcevt_checker #(
   parameter int unsigned ADDR_W = 4,
   parameter int unsigned CNT_W  = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] bus_addr,
   input logic              bus_we,
   input logic              wdata_b0,
   input logic              irq_out,
   input logic              tick,
   input logic              run_en,
   input logic              repeat_en,
   input logic              irq_en,
   input logic              evt_q,
   input logic [CNT_W-1:0]  reload_q,
   input logic [CNT_W-1:0]  live_q
);

   logic cnt_touch;
   logic stat_clr;

   assign cnt_touch = bus_we && ((bus_addr == ADDR_W'(0)) || (bus_addr == ADDR_W'(4)));
   assign stat_clr  = bus_we && (bus_addr == ADDR_W'(12)) && wdata_b0;

   assert_tick_gated_R4: assert property (@(posedge clk) disable iff (!rst_n)
      tick |-> run_en);

   assert_decrement_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && live_q > CNT_W'(1) && !cnt_touch) |=> (live_q == $past(live_q) - CNT_W'(1)));

   assert_oneshot_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (run_en && !repeat_en && live_q == '0 && !cnt_touch) |=> (live_q == '0));

   assert_reload_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && repeat_en && live_q == CNT_W'(1) && !cnt_touch) |=> (live_q == $past(reload_q)));

   assert_w1c_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_clr && !(tick && live_q == CNT_W'(1))) |=> !evt_q);

   assert_irq_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (!irq_en || !evt_q) |-> !irq_out);

   assert_stopped_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!run_en && !cnt_touch) |=> $stable(live_q));

   assert_set_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && live_q == CNT_W'(1) && !cnt_touch) |=> evt_q);

endmodule

bind dcount_evt_timer dcevt_checker #(
   .ADDR_W (ADDR_W),
   .CNT_W  (CNT_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_addr  (bus_addr),
   .bus_we    (bus_we),
   .wdata_b0  (bus_wdata[0]),
   .irq_out   (irq_out),
   .tick      (tick),
   .run_en    (run_en),
   .repeat_en (repeat_en),
   .irq_en    (irq_en),
   .evt_q     (evt_q),
   .reload_q  (reload_q),
   .live_q    (live_q)
);

// File: tb/dcount_evt_timer_test.sv
module dcount_evt_timer_test;

   localparam logic [3:0] A_RELOAD = 4'h0;
   localparam logic [3:0] A_LIVE   = 4'h4;
   localparam logic [3:0] A_CTRL   = 4'h8;
   localparam logic [3:0] A_STAT   = 4'hC;

   typedef struct {
      bit          is_irq;
      logic [31:0] exp;
      string       tag;
   } item_t;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [3:0]  bus_addr = '0;
   logic        bus_we = 1'b0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        irq_out;

   int total = 0;
   int bad = 0;
   bit done = 1'b0;
   item_t sb_q[$];

   always #10 clk = ~clk;

   dcount_evt_timer uut (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_addr  (bus_addr),
      .bus_we    (bus_we),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .irq_out   (irq_out)
   );

   // monitor: compares in the middle of the cycle
   always @(negedge clk) begin
      item_t it;
      logic [31:0] got;
      if (sb_q.size() > 0) begin
         it = sb_q.pop_front();
         got = it.is_irq ? {31'b0, irq_out} : bus_rdata;
         total++;
         if (got !== it.exp) begin
            bad++;
            $display("FAIL %s: got %h expected %h", it.tag, got, it.exp);
         end
      end
   end

   task automatic wr(input logic [3:0] a, input logic [31:0] d);
      bus_addr = a;
      bus_wdata = d;
      bus_we = 1'b1;
      @(posedge clk); #1;
      bus_we = 1'b0;
   endtask

   task automatic rd(input logic [3:0] a, input logic [31:0] e, input string tag);
      item_t it;
      bus_addr = a;
      it.is_irq = 1'b0;
      it.exp = e;
      it.tag = tag;
      sb_q.push_back(it);
      @(posedge clk); #1;
   endtask

   task automatic rd_irq(input logic e, input string tag);
      item_t it;
      it.is_irq = 1'b1;
      it.exp = {31'b0, e};
      it.tag = tag;
      sb_q.push_back(it);
      @(posedge clk); #1;
   endtask

   task automatic idle(input int n);
      repeat (n) begin
         @(posedge clk); #1;
      end
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;

      // R1: reset state
      rd(A_RELOAD, 32'h0, "R1 reload after reset");
      rd(A_LIVE,   32'h0, "R1 count after reset");
      rd(A_CTRL,   32'h0, "R1 control after reset");
      rd(A_STAT,   32'h0, "R1 status after reset");
      rd_irq(1'b0, "R1 irq after reset");

      // R2: control layout, unused bits read zero
      wr(A_CTRL, 32'hFFFF_FFF8);
      rd(A_CTRL, 32'h0000_FF00, "R2 divider field only");
      wr(A_CTRL, 32'h0000_0006);
      rd(A_CTRL, 32'h0000_0006, "R2 mode and irq bits");
      wr(A_CTRL, 32'h0);

      // R3: reload write copies into live count
      wr(A_RELOAD, 32'd5);
      rd(A_RELOAD, 32'd5, "R3 reload readback");
      rd(A_LIVE,   32'd5, "R3 count copy");

      // R11: misaligned accesses ignored
      wr(4'h1, 32'h77);
      rd(A_RELOAD, 32'd5, "R11 misaligned write ignored");
      rd(4'h5, 32'h0, "R11 misaligned read zero");

      // R4/R5: single expiry, divider 0, irq enabled
      wr(A_RELOAD, 32'd4);
      wr(A_CTRL, 32'h0000_0005);
      rd(A_LIVE, 32'd4, "R4 no tick on start edge");
      rd(A_LIVE, 32'd3, "R4 first decrement");
      rd(A_STAT, 32'd0, "R5 no event before zero");
      rd(A_LIVE, 32'd1, "R4 later decrement");
      rd(A_STAT, 32'd1, "R5 event at zero");
      rd_irq(1'b1, "R8 irq with enable");
      idle(3);
      rd(A_LIVE, 32'd0, "R5 holds at zero");
      rd(A_STAT, 32'd1, "R5 flag sticky");

      // R7: write-one-to-clear
      wr(A_STAT, 32'h0);
      rd(A_STAT, 32'd1, "R7 zero write keeps flag");
      wr(A_STAT, 32'h1);
      rd(A_STAT, 32'd0, "R7 one write clears flag");
      rd_irq(1'b0, "R8 irq drops with flag");

      // R6: repeating, first interval 2, period 3, divider 1, irq off
      wr(A_CTRL, 32'h0);
      wr(A_RELOAD, 32'd3);
      wr(A_LIVE, 32'd2);
      wr(A_CTRL, 32'h0000_0103);
      rd(A_STAT, 32'd0, "R6 no event at start");
      idle(2);
      rd(A_STAT, 32'd0, "R4 divider slows count");
      rd(A_STAT, 32'd1, "R6 first expiry from count write");
      rd(A_LIVE, 32'd3, "R6 reload on expiry");
      rd_irq(1'b0, "R8 irq masked when disabled");
      wr(A_STAT, 32'h1);
      rd(A_STAT, 32'd0, "R7 clear in repeating mode");
      rd(A_LIVE, 32'd1, "R6 counting second period");
      rd(A_STAT, 32'd1, "R6 second expiry after reload value");
      rd(A_LIVE, 32'd3, "R6 second reload");

      // R9: stop holds the count
      wr(A_CTRL, 32'h0);
      idle(4);
      rd(A_LIVE, 32'd2, "R9 count holds after stop");
      rd(A_CTRL, 32'h0, "R9 control zero");

      // R10: clear colliding with expiry
      wr(A_STAT, 32'h1);
      wr(A_RELOAD, 32'd3);
      wr(A_CTRL, 32'h0000_0001);
      idle(2);
      wr(A_STAT, 32'h1);
      rd(A_STAT, 32'd1, "R10 set beats clear");
      rd(A_LIVE, 32'd0, "R5 single expiry reached zero");
      rd_irq(1'b0, "R8 irq low with enable clear");

      @(negedge clk); #1;
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog: got running expected finished");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule